// File: doc/BRIEF.md
# Transmit FIFO with Empty-Space Watermark Request

This block is the transmit side buffer of a serial port. A CPU or DMA engine pushes data words into a sixteen-entry first-in first-out store, and the serial shifter pops them in the order they were written. A registered transfer request tells the CPU or DMA engine when there is enough free room to send another burst. A programmable watermark code selects how much free room is enough.

A 16-bit control/status word holds the watermark code in its top three bits, and shows the number of free entries in bits 12 to 8. That count is 16 when the store is empty and 0 when it is full. The word also stores a receive watermark code, which this block does not use. Whatever watermark is chosen, all sixteen entries are always available. A push into a full store is discarded and sets a sticky overflow flag. A pop from an empty store returns zero and changes nothing.

Top module: `txfifo_wm_req`

## Requirements
- R1: While reset is active and right after it, the control word reads 16'h1000, `tx_req` is 0 and `ovf_flag` is 0.
- R2: Words come out in the order they were written, and the store accepts 16 words before it is full.
- R3: Bits 12:8 of `reg_rdata` always give 16 minus the number of stored words.
- R4: Watermark code 3'b000 in bits 15:13 raises the request only when all 16 entries are free.
- R5: Code 3'b100 requests when at least 12 entries are free, 3'b101 when at least 8 are free, 3'b110 when at least 4 are free, and 3'b111 when at least 1 is free.
- R6: Reserved codes 3'b001, 3'b010 and 3'b011 are stored and read back as written, but the request behaves as it does for 3'b000.
- R7: The usable depth stays at 16 entries under every watermark code.
- R8: A push while 16 words are stored is discarded, leaves the stored words unchanged, and sets `ovf_flag`. The flag stays set until reset.
- R9: With the store empty, `rd_data` is zero, and a pop leaves the free count at 16.
- R10: `tx_req` is a register. It follows a change in occupancy one clock cycle after the cycle in which the count changes.
- R11: Bits 7:5 store a receive watermark that can be read and written. Bits 4:0 always read zero. Writes to bits 12:8 and 4:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push one word |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | DATA_W | Head word, or zero when the store is empty |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Value to write into the control word |
| reg_rdata | output | 16 | Current control/status word |
| tx_req | output | 1 | Registered transfer request |
| ovf_flag | output | 1 | Sticky flag for a discarded push |

## Verification
A wrong occupancy count shows up at once in bits 12:8 of the control word. One cycle later it also shows up in `tx_req` at the thresholds of the selected code, so the bench sets each code to exactly the fill level at the edge of its threshold and to one word past it. A pointer that goes wrong shows up at `rd_data` on the next pop as a word out of order or a wrong word. A full-store check that is missing overwrites the oldest word, and that wrong word appears on the first pop after the overflow.

// File: rtl/txfifo_wm_pkg.sv
package txfifo_wm_pkg;

  localparam int unsigned TXF_DEPTH = 16;
  localparam int unsigned TXF_CNT_W = $clog2(TXF_DEPTH + 1);
  localparam int unsigned TXF_PTR_W = $clog2(TXF_DEPTH);

  typedef logic [2:0]           wm_code_t;
  typedef logic [TXF_CNT_W-1:0] txf_cnt_t;

  localparam wm_code_t WM_ALL   = 3'b000;
  localparam wm_code_t WM_3Q    = 3'b100;
  localparam wm_code_t WM_HALF  = 3'b101;
  localparam wm_code_t WM_1Q    = 3'b110;
  localparam wm_code_t WM_ONE   = 3'b111;

  // Free entries required before a request is raised.
  // Reserved codes fall back to the all-empty threshold.
  function automatic txf_cnt_t wm_free_threshold(input wm_code_t code);
    case (code)
      WM_3Q:   return txf_cnt_t'((TXF_DEPTH * 3) / 4);
      WM_HALF: return txf_cnt_t'(TXF_DEPTH / 2);
      WM_1Q:   return txf_cnt_t'(TXF_DEPTH / 4);
      WM_ONE:  return txf_cnt_t'(1);
      default: return txf_cnt_t'(TXF_DEPTH);
    endcase
  endfunction

  function automatic txf_cnt_t free_entries(input txf_cnt_t level);
    return txf_cnt_t'(TXF_DEPTH) - level;
  endfunction

endpackage

// File: rtl/txf_store.sv
module txf_store
  import txfifo_wm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output txf_cnt_t          level,
  output logic              wr_drop
);

  localparam txf_cnt_t LVL_FULL = txf_cnt_t'(TXF_DEPTH);
  localparam logic [TXF_PTR_W-1:0] PTR_LAST = TXF_PTR_W'(TXF_DEPTH - 1);

  logic [DATA_W-1:0]    mem_q [TXF_DEPTH];
  logic [TXF_PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  txf_cnt_t             level_q;

  logic is_full, is_empty, wr_ok, rd_ok;

  assign is_full  = (level_q == LVL_FULL);
  assign is_empty = (level_q == '0);
  assign wr_ok    = wr_en && !is_full;
  assign rd_ok    = rd_en && !is_empty;
  assign wr_drop  = wr_en && is_full;

  function automatic logic [TXF_PTR_W-1:0] ptr_step(input logic [TXF_PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_step(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_step(rd_ptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign rd_data = is_empty ? '0 : mem_q[rd_ptr_q];
  assign level   = level_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_FULL); // R2
  AST_FULL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && wr_en && !rd_en) |=> (level_q == LVL_FULL) && $stable(wr_ptr_q)); // R8
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_en && !wr_en) |=> (level_q == '0) && $stable(rd_ptr_q)); // R9

endmodule

// File: rtl/txf_req_gen.sv
module txf_req_gen
  import txfifo_wm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wm_code_t code,
  input  txf_cnt_t level,
  output logic     tx_req
);

  localparam txf_cnt_t LVL_FULL = txf_cnt_t'(TXF_DEPTH);

  txf_cnt_t thr, free_now;
  logic     req_d, req_q;

  assign thr      = wm_free_threshold(code);
  assign free_now = free_entries(level);
  assign req_d    = (free_now >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign tx_req = req_q;

  AST_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |=> tx_req); // R4
  AST_NO_REQ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_FULL) |=> !tx_req); // R10
  AST_RESERVED_AS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((code == 3'b001 || code == 3'b010 || code == 3'b011) && level != '0) |=> !tx_req); // R6

endmodule

// File: rtl/txf_ctl_reg.sv
module txf_ctl_reg
  import txfifo_wm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  input  txf_cnt_t    level,
  input  logic        wr_drop,
  output logic [15:0] reg_rdata,
  output wm_code_t    tx_code,
  output logic        ovf_flag
);

  wm_code_t tx_wm_q, rx_wm_q;
  logic     ovf_q;
  txf_cnt_t usable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wm_q <= WM_ALL;
      rx_wm_q <= WM_ALL;
      ovf_q   <= 1'b0;
    end else begin
      if (reg_we) begin
        tx_wm_q <= reg_wdata[15:13];
        rx_wm_q <= reg_wdata[7:5];
      end
      if (wr_drop) ovf_q <= 1'b1;
    end
  end

  assign usable    = free_entries(level);
  assign reg_rdata = {tx_wm_q, usable, rx_wm_q, 5'b00000};
  assign tx_code   = tx_wm_q;
  assign ovf_flag  = ovf_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> ovf_q); // R8
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(tx_wm_q) && $stable(rx_wm_q)); // R11

endmodule

// File: rtl/txfifo_wm_req.sv
module txfifo_wm_req
  import txfifo_wm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              reg_we,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              tx_req,
  output logic              ovf_flag
);

  txf_cnt_t level;
  logic     wr_drop;
  wm_code_t tx_code;

  txf_store #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .level   (level),
    .wr_drop (wr_drop)
  );

  txf_req_gen u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .code   (tx_code),
    .level  (level),
    .tx_req (tx_req)
  );

  txf_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .level     (level),
    .wr_drop   (wr_drop),
    .reg_rdata (reg_rdata),
    .tx_code   (tx_code),
    .ovf_flag  (ovf_flag)
  );

  AST_UA_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_drop && !rd_en) |=> reg_rdata[12:8] == $past(reg_rdata[12:8]) - 5'd1); // R3

endmodule

// File: tb/txfifo_wm_req_tb_top.sv
module txfifo_wm_req_tb_top;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, reg_we = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [15:0]   reg_wdata = '0;
  logic [DW-1:0] rd_data;
  logic [15:0]   reg_rdata;
  logic          tx_req, ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  txfifo_wm_req #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_req(tx_req), .ovf_flag(ovf_flag)
  );

  // {code[2:0], fill[4:0], expected request}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {3'b000, 5'd0,  1'b1}, {3'b000, 5'd1,  1'b0},
    {3'b100, 5'd4,  1'b1}, {3'b100, 5'd5,  1'b0},
    {3'b101, 5'd8,  1'b1}, {3'b101, 5'd9,  1'b0},
    {3'b110, 5'd12, 1'b1}, {3'b110, 5'd13, 1'b0},
    {3'b111, 5'd15, 1'b1}, {3'b111, 5'd16, 1'b0},
    {3'b001, 5'd0,  1'b1}, {3'b010, 5'd1,  1'b0},
    {3'b011, 5'd0,  1'b1}, {3'b000, 5'd16, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; reg_we = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk); reg_we = 1'b1; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic pop(output logic [DW-1:0] v);
    @(negedge clk); rd_en = 1'b1; v = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] got;
    // R1: reset state
    @(negedge clk);
    chk("R1 reg", 32'(reg_rdata), 32'h1000);
    chk("R1 req", 32'(tx_req), 0);
    chk("R1 ovf", 32'(ovf_flag), 0);

    // R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      reg_write({VEC[i][8:6], 13'd0});
      for (int k = 0; k < int'(VEC[i][5:1]); k++) push(DW'(k + 1));
      @(negedge clk); @(negedge clk);
      chk($sformatf("R4/R5/R6 row %0d req", i), 32'(tx_req), 32'(VEC[i][0]));
      chk($sformatf("R3 row %0d ua", i), 32'(reg_rdata[12:8]), 32'(5'd16 - VEC[i][5:1]));
      chk($sformatf("R6 row %0d code", i), 32'(reg_rdata[15:13]), 32'(VEC[i][8:6]));
    end

    // R2 R7: full depth under code 110, order preserved
    do_reset();
    reg_write(16'hC000);
    for (int k = 0; k < 16; k++) push(DW'(3 * k + 1));
    @(negedge clk);
    chk("R7 ua full", 32'(reg_rdata[12:8]), 0);
    chk("R7 no ovf", 32'(ovf_flag), 0);
    // R8: push into full store
    push(8'hAA);
    @(negedge clk);
    chk("R8 ovf set", 32'(ovf_flag), 1);
    chk("R8 ua", 32'(reg_rdata[12:8]), 0);
    for (int k = 0; k < 16; k++) begin
      pop(got);
      chk("R2 order", 32'(got), 32'(3 * k + 1));
    end
    @(negedge clk);
    chk("R8 sticky", 32'(ovf_flag), 1);

    // R9: empty read
    chk("R9 zero data", 32'(rd_data), 0);
    pop(got);
    chk("R9 pop zero", 32'(got), 0);
    @(negedge clk);
    chk("R9 ua", 32'(reg_rdata[12:8]), 16);
    push(8'h5C);
    @(negedge clk);
    chk("R9 next write", 32'(rd_data), 32'h5C);

    // R10: one-cycle request latency, code 000
    do_reset();
    @(negedge clk); @(negedge clk);
    chk("R10 idle req", 32'(tx_req), 1);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 count moved", 32'(reg_rdata[12:8]), 15);
    chk("R10 req unchanged", 32'(tx_req), 1);
    @(negedge clk);
    chk("R10 req dropped", 32'(tx_req), 0);

    // R11: receive fields and read-only bits
    reg_write(16'hFFFF);
    chk("R11 readback", 32'(reg_rdata), 32'hEFE0);
    reg_write(16'h00A0);
    chk("R11 rx only", 32'(reg_rdata), 32'h0FA0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule